// File: doc/BRIEF.md
# Line CRC Checker for HD Video

This block checks the per-line CRC of a high-definition serial digital video stream after it has been deserialized and split into parallel 10-bit luma (Y) and chroma (C) words. Two independent CRC engines, one per channel, run over each line from the first active-video word up to and including the two line-number words that follow the end-of-active-video marker. The result of each engine is compared with the two CRC words that come after the line-number words.

A mismatch raises that channel's sticky error flag. If the CRC words never arrive, both flags are raised. A CRC word with a broken format also counts as an error on its channel. The flags stay HIGH until the host pulses the clear input. Checking is active only while the mode input selects HD. In SD mode no flag is ever raised.

Upstream logic supplies a word-valid strobe and two decoded marker strobes. The start marker is asserted on the last word of the start-of-active-video sequence. The end marker is asserted on the last word of the end-of-active-video sequence.

Top module: `lcrc_line_checker`

## Requirements
- R1: After reset both error flags (`y_crc_err`, `c_crc_err`) are LOW.
- R2: The Y engine starts from zero and covers every valid word after the word carrying `sav_mk`, through the second word after the word carrying `eav_mk`. That range includes the end-marker words. Each word is fed bit-serially, LSB first: feedback = crc[0] XOR bit, the register shifts right, and the feedback is placed into bit 17 and XORed into bits 13 and 12 (generator x^18 + x^5 + x^4 + 1). A mismatch sets `y_crc_err`.
- R3: The C engine follows the same rules on `c_word`, independently of Y. A C mismatch sets only `c_crc_err`, and a Y mismatch sets only `y_crc_err`.
- R4: The third valid word after the end marker carries crc[8:0] in bits 8:0. The fourth carries crc[17:9] in bits 8:0. In both words bit 9 must be the inverse of bit 8, and a violation sets that channel's flag.
- R5: A word carrying `sav_mk` or `eav_mk` that arrives before the fourth word after an end marker means the CRC is missing. It sets both flags.
- R6: While `hd_mode` is LOW no flag is set, whatever the data.
- R7: Flags are sticky. A flag stays HIGH until an `err_clr` pulse, which clears it on the next edge.
- R8: When an error is detected in the same cycle as `err_clr`, the flag ends HIGH.
- R9: Each line's CRC restarts from zero, so data from earlier lines has no effect on the result.
- R10: A flag changes on the clock edge that samples the fourth CRC-position word (or the early marker), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| word_vld | input | 1 | Y and C words are valid this cycle |
| hd_mode | input | 1 | HIGH = HD (checking on), LOW = SD |
| y_word | input | 10 | Luma word |
| c_word | input | 10 | Chroma word |
| sav_mk | input | 1 | Word is the last word of the start-of-active-video marker |
| eav_mk | input | 1 | Word is the last word of the end-of-active-video marker |
| err_clr | input | 1 | Host clear pulse for both flags |
| y_crc_err | output | 1 | Sticky luma CRC error |
| c_crc_err | output | 1 | Sticky chroma CRC error |

## Verification
Error detection and the host clear can fall in the same cycle. The bench provokes this by pulsing `err_clr` together with the fourth CRC word of a line whose luma CRC is corrupted, and it expects the flag to be HIGH afterwards. A second collision is a marker landing in the CRC window: the early marker must raise both flags at once. Around it, neighbouring lines are checked to confirm that neither flag is lost or raised spuriously.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;
  localparam int WORD_W = 10;
  localparam int CRC_W  = 18;
  localparam int HALF_W = CRC_W / 2;
  localparam int POS_W  = 3;
  localparam int NCHAN  = 2;

  // One word into the CRC, LSB first, generator x^18 + x^5 + x^4 + 1
  function automatic logic [CRC_W-1:0] crc_feed(input logic [CRC_W-1:0] cur,
                                                input logic [WORD_W-1:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int i = 0; i < WORD_W; i++) begin
      fb = c[0] ^ din[i];
      c = {fb, c[CRC_W-1:1]};
      c[13] = c[13] ^ fb;
      c[12] = c[12] ^ fb;
    end
    return c;
  endfunction

  // A CRC-carrying word is well formed when bit 9 is the inverse of bit 8
  function automatic logic fmt_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] != w[WORD_W-2];
  endfunction
endpackage

// File: rtl/lcrc_line_track.sv
module lcrc_line_track
  import lcrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic word_vld,
  input  logic sav_mk,
  input  logic eav_mk,
  output logic start,
  output logic acc_en,
  output logic cap_lo,
  output logic cmp_hi,
  output logic miss
);
  localparam logic [POS_W-1:0] P_IDLE = 3'd0;
  localparam logic [POS_W-1:0] P_LN1  = 3'd2;
  localparam logic [POS_W-1:0] P_CR0  = 3'd3;
  localparam logic [POS_W-1:0] P_CR1  = 3'd4;

  logic [POS_W-1:0] pos_q;
  logic             in_act_q;
  logic             mark;

  assign mark   = sav_mk | eav_mk;
  assign start  = word_vld & sav_mk;
  assign acc_en = word_vld & in_act_q & ~sav_mk;
  assign cap_lo = word_vld & ~mark & (pos_q == P_CR0);
  assign cmp_hi = word_vld & ~mark & (pos_q == P_CR1);
  assign miss   = word_vld & mark & (pos_q != P_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= P_IDLE;
      in_act_q <= 1'b0;
    end else if (word_vld) begin
      if (eav_mk)                pos_q <= 3'd1;
      else if (sav_mk)           pos_q <= P_IDLE;
      else if (pos_q == P_CR1)   pos_q <= P_IDLE;
      else if (pos_q != P_IDLE)  pos_q <= pos_q + 3'd1;

      if (sav_mk)                in_act_q <= 1'b1;
      else if (pos_q == P_LN1)   in_act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lcrc_chan.sv
module lcrc_chan
  import lcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              start,
  input  logic              acc_en,
  input  logic              cap_lo,
  input  logic              cmp_hi,
  output logic              bad
);
  logic [CRC_W-1:0]  crc_q;
  logic [HALF_W-1:0] lo_q;
  logic              lo_bad_q;
  logic [CRC_W-1:0]  rx_crc;

  assign rx_crc = {word[HALF_W-1:0], lo_q};
  assign bad    = cmp_hi & ((rx_crc != crc_q) | lo_bad_q | ~fmt_ok(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '0;
      lo_q     <= '0;
      lo_bad_q <= 1'b0;
    end else begin
      if (start)       crc_q <= '0;
      else if (acc_en) crc_q <= crc_feed(crc_q, word);
      if (cap_lo) begin
        lo_q     <= word[HALF_W-1:0];
        lo_bad_q <= ~fmt_ok(word);
      end
    end
  end
endmodule

// File: rtl/lcrc_flags.sv
module lcrc_flags
  import lcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NCHAN-1:0] set_ev,
  output logic [NCHAN-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_ev | (clr ? '0 : flags);
  end
endmodule

// File: rtl/lcrc_line_checker.sv
module lcrc_line_checker
  import lcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              hd_mode,
  input  logic [WORD_W-1:0] y_word,
  input  logic [WORD_W-1:0] c_word,
  input  logic              sav_mk,
  input  logic              eav_mk,
  input  logic              err_clr,
  output logic              y_crc_err,
  output logic              c_crc_err
);
  logic              start_ev, acc_ev, cap_ev, cmp_ev, miss_ev;
  logic [NCHAN-1:0]  bad_ev;
  logic [NCHAN-1:0]  set_ev;
  logic [NCHAN-1:0]  flags;
  logic [WORD_W-1:0] chan_word [NCHAN];

  assign chan_word[0] = y_word;
  assign chan_word[1] = c_word;

  lcrc_line_track u_track (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .sav_mk(sav_mk), .eav_mk(eav_mk),
    .start(start_ev), .acc_en(acc_ev), .cap_lo(cap_ev), .cmp_hi(cmp_ev), .miss(miss_ev)
  );

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    lcrc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .word(chan_word[g]), .start(start_ev),
      .acc_en(acc_ev), .cap_lo(cap_ev), .cmp_hi(cmp_ev), .bad(bad_ev[g])
    );
    assign set_ev[g] = hd_mode & (bad_ev[g] | miss_ev);
  end

  lcrc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .set_ev(set_ev), .flags(flags)
  );

  assign y_crc_err = flags[0];
  assign c_crc_err = flags[1];
endmodule

// File: rtl/lcrc_checker.sv
module lcrc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hd_mode,
  input logic       err_clr,
  input logic       miss_ev,
  input logic [1:0] set_ev,
  input logic       y_crc_err,
  input logic       c_crc_err
);
  assert_sd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd_mode && !y_crc_err && !c_crc_err) |=> (!y_crc_err && !c_crc_err));

  assert_set_needs_hd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != 2'b00) |-> hd_mode);

  assert_missing_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev && hd_mode) |=> (y_crc_err && c_crc_err));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (y_crc_err && !err_clr) |=> y_crc_err);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !set_ev[0] && !set_ev[1]) |=> (!y_crc_err && !c_crc_err));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev[0] && err_clr) |=> y_crc_err);

  assert_c_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[1] |=> c_crc_err);
endmodule

bind lcrc_line_checker lcrc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hd_mode(hd_mode), .err_clr(err_clr),
  .miss_ev(miss_ev), .set_ev(set_ev), .y_crc_err(y_crc_err), .c_crc_err(c_crc_err)
);

// File: tb/tb_lcrc_line_checker.sv
module tb_lcrc_line_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_vld = 1'b0, hd_mode = 1'b1, sav_mk = 1'b0, eav_mk = 1'b0, err_clr = 1'b0;
  logic [9:0] y_word = '0, c_word = '0;
  logic y_crc_err, c_crc_err;

  int checks = 0, errors = 0;
  logic [17:0] ycrc, ccrc;
  logic exp_y = 1'b0, exp_c = 1'b0;
  logic [1:0] exp_q [$];
  string tag_q [$];
  event line_done;

  always #5 clk = ~clk;

  lcrc_line_checker dut (.*);

  // Bench CRC: right-shift register with reflected mask of x^18+x^5+x^4+1
  function automatic logic [17:0] bcrc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r = c;
    for (int b = 0; b < 10; b++) begin
      logic fb = r[0] ^ w[b];
      r = r >> 1;
      if (fb) r = r ^ 18'h23000;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags y/c actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] y, input logic [9:0] c, input logic s, input logic e,
                     input logic cov, input logic cl);
    @(negedge clk);
    word_vld = 1'b1; y_word = y; c_word = c; sav_mk = s; eav_mk = e; err_clr = cl;
    if (s) begin ycrc = '0; ccrc = '0; end
    if (cov) begin ycrc = bcrc(ycrc, y); ccrc = bcrc(ccrc, c); end
  endtask

  task automatic expect_now(input string tag);
    @(negedge clk);
    word_vld = 1'b0; sav_mk = 1'b0; eav_mk = 1'b0; err_clr = 1'b0;
    exp_q.push_back({exp_y, exp_c});
    tag_q.push_back(tag);
    -> line_done;
    @(negedge clk);
  endtask

  // Sends a complete line with optional corruption of the CRC words
  task automatic send_line(input string tag, input int n, input logic hd,
                           input logic y_flip, input logic c_flip, input logic y_b9,
                           input logic cl_last);
    logic [9:0] y0, y1, c0, c1;
    hd_mode = hd;
    put(10'h200, 10'h200, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) put(10'($urandom), 10'($urandom), 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h274, 10'h274, 1'b0, 1'b1, 1'b1, 1'b0);
    put(10'h288, 10'h288, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h200, 10'h200, 1'b0, 1'b0, 1'b1, 1'b0);
    y0 = {~ycrc[8], ycrc[8:0]};   y1 = {~ycrc[17], ycrc[17:9]};
    c0 = {~ccrc[8], ccrc[8:0]};   c1 = {~ccrc[17], ccrc[17:9]};
    if (y_flip) begin y0[0] = ~y0[0]; end
    if (c_flip) begin c1[3] = ~c1[3]; end
    if (y_b9)   begin y1[9] = ~y1[9]; end
    put(y0, c0, 1'b0, 1'b0, 1'b0, 1'b0);
    put(y1, c1, 1'b0, 1'b0, 1'b0, cl_last);
    // R10: before the edge sampling the last CRC word, flags are unchanged
    check({tag, " R10 before edge"}, {y_crc_err, c_crc_err}, {exp_y, exp_c});
    if (cl_last) begin exp_y = 1'b0; exp_c = 1'b0; end
    exp_y = exp_y | (hd & (y_flip | y_b9));
    exp_c = exp_c | (hd & c_flip);
    expect_now(tag);
  endtask

  task automatic clear_flags(input string tag);
    @(negedge clk);
    word_vld = 1'b0; err_clr = 1'b1;
    exp_y = 1'b0; exp_c = 1'b0;
    expect_now(tag);
  endtask

  // Monitor: pops expected flag pairs and compares them with the outputs
  initial begin
    forever begin
      @(line_done);
      #1;
      check(tag_q.pop_front(), {y_crc_err, c_crc_err}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {y_crc_err, c_crc_err}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {y_crc_err, c_crc_err}, 2'b00);

    send_line("R2 R3 good line", 24, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_line("R2 Y mismatch", 20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    clear_flags("R7 clear after Y");
    send_line("R3 C mismatch only", 31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    clear_flags("R7 clear after C");
    send_line("R4 Y bit9 broken", 17, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_flags("R7 clear after format");

    // R5: SAV arrives after the line numbers instead of the CRC words
    hd_mode = 1'b1;
    put(10'h200, 10'h200, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) put(10'($urandom), 10'($urandom), 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h274, 10'h274, 1'b0, 1'b1, 1'b1, 1'b0);
    put(10'h288, 10'h288, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h200, 10'h200, 1'b0, 1'b0, 1'b1, 1'b0);
    put(10'h200, 10'h200, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_y = 1'b1; exp_c = 1'b1;
    expect_now("R5 missing CRC words");
    clear_flags("R7 clear after missing");

    send_line("R6 SD mode corrupt", 22, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    send_line("R2 Y set again", 19, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send_line("R7 sticky across good line", 26, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_line("R8 clear with error same cycle", 21, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    send_line("R8 clear on good line", 15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send_line("R9 line A", 40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_line("R9 line B restart", 11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_line("R3 C mismatch late", 33, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule